// File: doc/BRIEF.md
# Serial-Command Reset and Sync Controller

This block sits between a slow serial command port (a serial clock and a data line) and the digital part of a converter. It also takes an asynchronous active-low reset pin. It turns these inputs into a chip reset, a one-cycle clear for the decimation filter counter, a modulator hold and an active-low data-ready flag. Everything runs on the system clock `clk`. The serial clock and data are brought into that domain through a short synchroniser chain, and the block acts on the detected edges.

A reset can come from three places. The first is the pin, which must stay low long enough to pass a glitch filter. The second is a reset command byte. The third is a fixed rhythm of long and short serial-clock high pulses. The command and pattern resets end by themselves after a fixed number of cycles. A sync command clears the filter counter and holds the modulator until the next serial-clock rising edge. A stub conversion counter then signals fresh data a fixed number of cycles after the hold lifts.

Top module: `rc_reset_sync_ctrl`

## Requirements
- R1: When `rst_pin_n` goes low between clock edges, `chip_rst_o` rises just after the sixth following rising edge of `clk` and stays high while the pin is low. After the pin returns high, `chip_rst_o` falls just after the third following rising edge.
- R2: A low pulse on `rst_pin_n` that covers at most 3 rising edges of `clk` never raises `chip_rst_o`. A pulse that covers 4 or more does raise it.
- R3: Command bytes are shifted MSB first on `sclk` rising edges. The byte 0xFE is the reset command. It raises `chip_rst_o` just after the third `clk` rising edge following its eighth `sclk` rise, and it has no effect after only seven bits.
- R4: A reset from the command or from the pulse pattern keeps `chip_rst_o` high for exactly 16 `clk` cycles and then releases it with no host action.
- R5: Four `sclk` high pulses measured in `clk` cycles, in the order long (at least 16), short (at most 4), long, short, raise `chip_rst_o` just after the third `clk` rising edge following the `sclk` falling edge that ends the fourth pulse.
- R6: A pulse that does not fit the expected step restarts the pattern search. A long pulse counts as a new first step. A full pattern that follows the deviation still triggers a reset.
- R7: The byte 0xFC is the sync command. Just after the third `clk` rising edge following its eighth `sclk` rise, `filt_clr_o` is high for exactly one cycle, and `mod_hold_o` and `drdy_n_o` both go high.
- R8: `mod_hold_o` stays high until the next `sclk` rising edge. It falls just after the third `clk` rising edge following that edge.
- R9: After `mod_hold_o` falls, `drdy_n_o` goes low exactly 12 `clk` cycles later. It never falls while the hold or the chip reset is active.
- R10: Any other complete command byte changes neither `chip_rst_o` nor `mod_hold_o`.
- R11: While `chip_rst_o` is high, the next cycle shows `drdy_n_o` high, and `mod_hold_o` and `filt_clr_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| sclk | input | 1 | Serial command clock, idles low |
| din | input | 1 | Serial command data, sampled on sclk rising edges |
| chip_rst_o | output | 1 | Active-high reset for the converter core |
| filt_clr_o | output | 1 | One-cycle clear of the decimation filter counter |
| mod_hold_o | output | 1 | Holds the modulator in reset after a sync |
| drdy_n_o | output | 1 | Active-low data-ready flag |

## Verification
Every `sclk` edge travels through two synchroniser stages and one state register. Its effect (command decode, pattern hit, hold release) therefore appears just after the third `clk` rising edge once the edge is presented. The pin path needs six edges to assert and three to release. The bench drives inputs on falling `clk` edges. It counts rising edges from the change and samples one nanosecond after the due edge, and it also checks the edge before, so that an early or late result is reported. Lengths such as the 16-cycle auto reset and the 12-cycle conversion are measured by sampling after each rising edge. Random command bytes and random pin pulse widths are checked against expected values from bench functions.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;
    // class of one measured sclk high pulse
    typedef enum logic [1:0] {
        PW_OTHER = 2'd0,
        PW_SHORT = 2'd1,
        PW_LONG  = 2'd2
    } pw_kind_e;

    typedef logic [7:0] cmd_byte_t;
endpackage

// File: rtl/rc_sclk_sync.sv
`timescale 1ns/1ps
module rc_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic sclk_i,
    input  logic din_i,
    output logic high_o,
    output logic rise_o,
    output logic fall_o,
    output logic din_o
);
    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES-1:0] dat;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sck = {s_q.sck[STAGES-1:0], sclk_i};
        s_d.dat = {s_q.dat[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign high_o = s_q.sck[STAGES-1];
    assign rise_o = s_q.sck[STAGES-1] & ~s_q.sck[STAGES];
    assign fall_o = ~s_q.sck[STAGES-1] & s_q.sck[STAGES];
    assign din_o  = s_q.dat[STAGES-1];
endmodule

// File: rtl/rc_pin_filter.sv
`timescale 1ns/1ps
module rc_pin_filter #(
    parameter int STAGES  = 2,
    parameter int LOW_MIN = 4
) (
    input  logic clk,
    input  logic pin_n_i,
    output logic rst_o
);
    localparam int LW = $clog2(LOW_MIN + 1);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic [LW-1:0]     low_cnt;
        logic              rst;
    } pf_t;

    pf_t p_d, p_q;
    logic pin_low;

    assign pin_low = ~p_q.sync[STAGES-1];

    always_comb begin
        p_d      = p_q;
        p_d.sync = {p_q.sync[STAGES-2:0], pin_n_i};
        if (!pin_low) begin
            p_d.low_cnt = '0;
        end else if (p_q.low_cnt != LW'(LOW_MIN)) begin
            p_d.low_cnt = p_q.low_cnt + 1'b1;
        end
        p_d.rst = pin_low && (p_q.low_cnt >= LW'(LOW_MIN - 1));
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    assign rst_o = p_q.rst;
endmodule

// File: rtl/rc_pattern_match.sv
`timescale 1ns/1ps
module rc_pattern_match
    import rc_pkg::*;
#(
    parameter int              PAT_LEN   = 4,
    parameter logic [PAT_LEN-1:0] PAT_SEQ = 4'b0101,
    parameter int              LONG_MIN  = 16,
    parameter int              SHORT_MAX = 4
) (
    input  logic clk,
    input  logic clr_i,
    input  logic high_i,
    input  logic fall_i,
    output logic hit_o
);
    localparam int CW = $clog2(LONG_MIN + 1);
    localparam int SW = $clog2(PAT_LEN);

    typedef struct packed {
        logic [CW-1:0] width;
        logic [SW-1:0] step;
    } pm_t;

    pm_t m_d, m_q;
    pw_kind_e kind;
    logic fits_step, fits_first, last_step;

    always_comb begin
        if (m_q.width >= CW'(LONG_MIN))       kind = PW_LONG;
        else if (m_q.width <= CW'(SHORT_MAX)) kind = PW_SHORT;
        else                                  kind = PW_OTHER;
        fits_step  = (kind == PW_LONG  &&  PAT_SEQ[m_q.step]) ||
                     (kind == PW_SHORT && !PAT_SEQ[m_q.step]);
        fits_first = (kind == PW_LONG  &&  PAT_SEQ[0]) ||
                     (kind == PW_SHORT && !PAT_SEQ[0]);
        last_step  = (m_q.step == SW'(PAT_LEN - 1));
    end

    assign hit_o = fall_i && fits_step && last_step && !clr_i;

    always_comb begin
        m_d = m_q;
        if (clr_i) begin
            m_d = '0;
        end else begin
            if (high_i) begin
                if (m_q.width != CW'(LONG_MIN)) m_d.width = m_q.width + 1'b1;
            end else begin
                m_d.width = '0;
            end
            if (fall_i) begin
                if (fits_step) m_d.step = last_step ? '0 : m_q.step + 1'b1;
                else           m_d.step = fits_first ? SW'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        m_q <= m_d;
    end
endmodule

// File: rtl/rc_reset_sync_ctrl.sv
`timescale 1ns/1ps
module rc_reset_sync_ctrl
    import rc_pkg::*;
#(
    parameter int        STAGES    = 2,
    parameter int        LOW_MIN   = 4,
    parameter int        AUTO_LEN  = 16,
    parameter int        CONV_LEN  = 12,
    parameter int        PAT_LEN   = 4,
    parameter logic [PAT_LEN-1:0] PAT_SEQ = 4'b0101,
    parameter int        LONG_MIN  = 16,
    parameter int        SHORT_MAX = 4,
    parameter cmd_byte_t CMD_RESET = 8'hFE,
    parameter cmd_byte_t CMD_SYNC  = 8'hFC
) (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic sclk,
    input  logic din,
    output logic chip_rst_o,
    output logic filt_clr_o,
    output logic mod_hold_o,
    output logic drdy_n_o
);
    localparam int AW  = $clog2(AUTO_LEN + 1);
    localparam int CVW = $clog2(CONV_LEN);

    typedef struct packed {
        cmd_byte_t      shreg;
        logic [2:0]     bitcnt;
        logic [AW-1:0]  auto_cnt;
        logic [CVW-1:0] conv_cnt;
        logic           mod_hold;
        logic           drdy_n;
        logic           filt_clr;
    } ctl_t;

    ctl_t st_d, st_q;
    logic sck_high, sck_rise, sck_fall, din_s;
    logic pin_rst, pat_hit;
    cmd_byte_t byte_w;

    rc_sclk_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .sclk_i (sclk),
        .din_i  (din),
        .high_o (sck_high),
        .rise_o (sck_rise),
        .fall_o (sck_fall),
        .din_o  (din_s)
    );

    rc_pin_filter #(.STAGES(STAGES), .LOW_MIN(LOW_MIN)) u_pin (
        .clk     (clk),
        .pin_n_i (rst_pin_n),
        .rst_o   (pin_rst)
    );

    rc_pattern_match #(
        .PAT_LEN(PAT_LEN), .PAT_SEQ(PAT_SEQ),
        .LONG_MIN(LONG_MIN), .SHORT_MAX(SHORT_MAX)
    ) u_pat (
        .clk    (clk),
        .clr_i  (chip_rst_o),
        .high_i (sck_high),
        .fall_i (sck_fall),
        .hit_o  (pat_hit)
    );

    assign byte_w = {st_q.shreg[6:0], din_s};

    always_comb begin
        st_d          = st_q;
        st_d.filt_clr = 1'b0;
        if (pin_rst) begin
            st_d        = '0;
            st_d.drdy_n = 1'b1;
        end else if (st_q.auto_cnt != '0) begin
            st_d          = '0;
            st_d.drdy_n   = 1'b1;
            st_d.auto_cnt = st_q.auto_cnt - 1'b1;
        end else if (pat_hit) begin
            st_d          = '0;
            st_d.drdy_n   = 1'b1;
            st_d.auto_cnt = AW'(AUTO_LEN);
        end else begin
            if (sck_rise) begin
                st_d.shreg  = byte_w;
                st_d.bitcnt = st_q.bitcnt + 1'b1;
                if (st_q.mod_hold) st_d.mod_hold = 1'b0;
            end
            // stub conversion counter stands in for the decimation filter
            if (!st_q.mod_hold) begin
                if (st_q.conv_cnt == CVW'(CONV_LEN - 1)) begin
                    st_d.conv_cnt = '0;
                    st_d.drdy_n   = 1'b0;
                end else begin
                    st_d.conv_cnt = st_q.conv_cnt + 1'b1;
                end
            end
            if (sck_rise && st_q.bitcnt == 3'd7) begin
                if (byte_w == CMD_RESET) begin
                    st_d          = '0;
                    st_d.drdy_n   = 1'b1;
                    st_d.auto_cnt = AW'(AUTO_LEN);
                end else if (byte_w == CMD_SYNC) begin
                    st_d.filt_clr = 1'b1;
                    st_d.mod_hold = 1'b1;
                    st_d.drdy_n   = 1'b1;
                    st_d.conv_cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign chip_rst_o = pin_rst | (st_q.auto_cnt != '0);
    assign filt_clr_o = st_q.filt_clr;
    assign mod_hold_o = st_q.mod_hold;
    assign drdy_n_o   = st_q.drdy_n;
endmodule

module rc_reset_sync_chk (
    input logic clk,
    input logic rst_pin_n,
    input logic chip_rst_o,
    input logic filt_clr_o,
    input logic mod_hold_o,
    input logic drdy_n_o
);
    // R7
    filt_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        filt_clr_o |=> !filt_clr_o);

    // R7
    sync_outputs_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        filt_clr_o |-> (mod_hold_o && drdy_n_o));

    // R8
    hold_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        mod_hold_o |-> drdy_n_o);

    // R9
    ready_fall_free_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $fell(drdy_n_o) |-> (!mod_hold_o && !chip_rst_o));

    // R11
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        chip_rst_o |=> (drdy_n_o && !mod_hold_o && !filt_clr_o));
endmodule

bind rc_reset_sync_ctrl rc_reset_sync_chk u_chk (
    .clk        (clk),
    .rst_pin_n  (rst_pin_n),
    .chip_rst_o (chip_rst_o),
    .filt_clr_o (filt_clr_o),
    .mod_hold_o (mod_hold_o),
    .drdy_n_o   (drdy_n_o)
);

// File: tb/tb_rc_reset_sync_ctrl.sv
`timescale 1ns/1ps
module tb_rc_reset_sync_ctrl;
    localparam int HI = 6;
    localparam int LO = 3;

    logic clk = 1'b0;
    logic rst_pin_n = 1'b0;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic chip_rst_o, filt_clr_o, mod_hold_o, drdy_n_o;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rc_reset_sync_ctrl dut (
        .clk        (clk),
        .rst_pin_n  (rst_pin_n),
        .sclk       (sclk),
        .din        (din),
        .chip_rst_o (chip_rst_o),
        .filt_clr_o (filt_clr_o),
        .mod_hold_o (mod_hold_o),
        .drdy_n_o   (drdy_n_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // 0 none, 1 reset, 2 sync
    function automatic int cmd_effect(logic [7:0] b);
        if (b == 8'hFE) return 1;
        if (b == 8'hFC) return 2;
        return 0;
    endfunction

    function automatic bit pin_accepted(int low_len);
        return low_len >= 4;
    endfunction

    task automatic edge_wait(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rise(bit v);
        @(negedge clk);
        din = v;
        repeat (LO) @(negedge clk);
        sclk = 1'b1;
    endtask

    task automatic fall_after(int hi);
        repeat (hi) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            rise(b[7-i]);
            fall_after(HI);
        end
    endtask

    task automatic pulse(int hi);
        @(negedge clk);
        sclk = 1'b1;
        repeat (hi) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_rst_low();
        while (chip_rst_o !== 1'b0) @(negedge clk);
    endtask

    task automatic count_rst(output int len);
        len = 1;
        forever begin
            edge_wait(1);
            if (chip_rst_o) len++;
            else break;
        end
    endtask

    task automatic pin_pulse(int low_len, output bit saw);
        saw = 1'b0;
        @(negedge clk);
        rst_pin_n = 1'b0;
        for (int i = 0; i < low_len; i++) begin
            @(negedge clk);
            if (chip_rst_o) saw = 1'b1;
        end
        rst_pin_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (chip_rst_o) saw = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit saw;
        int len;
        logic [7:0] b;
        int e;
        void'($urandom(32'h5EED_0042));

        // reset state
        edge_wait(10);
        chk("R1 pin reset active", chip_rst_o, 1);
        chk("R11 drdy high in reset", drdy_n_o, 1);
        chk("R11 hold low in reset", mod_hold_o, 0);
        chk("R11 filt clear low in reset", filt_clr_o, 0);

        // release timing
        @(negedge clk);
        rst_pin_n = 1'b1;
        edge_wait(2);
        chk("R1 release not before third edge", chip_rst_o, 1);
        edge_wait(1);
        chk("R1 release on third edge", chip_rst_o, 0);
        edge_wait(20);
        chk("R9 free-running conversion ready", drdy_n_o, 0);

        // assertion timing
        @(negedge clk);
        rst_pin_n = 1'b0;
        edge_wait(5);
        chk("R1 not asserted before sixth edge", chip_rst_o, 0);
        edge_wait(1);
        chk("R1 asserted on sixth edge", chip_rst_o, 1);
        repeat (5) @(negedge clk);
        chk("R1 held while pin low", chip_rst_o, 1);
        rst_pin_n = 1'b1;
        wait_rst_low();

        // glitch filter, directed boundaries then random widths
        pin_pulse(3, saw);
        chk("R2 three-edge glitch ignored", saw, 0);
        pin_pulse(4, saw);
        chk("R2 four-edge pulse accepted", saw, 1);
        for (int k = 0; k < 8; k++) begin
            len = 1 + int'($urandom_range(7));
            pin_pulse(len, saw);
            chk("R2 random pin pulse", saw, pin_accepted(len));
        end
        repeat (20) @(negedge clk);

        // reset command
        send_bits(8'hFE, 7);
        edge_wait(4);
        chk("R3 no reset after seven bits", chip_rst_o, 0);
        rise(1'b0);
        edge_wait(2);
        chk("R3 reset not before third edge", chip_rst_o, 0);
        edge_wait(1);
        chk("R3 reset after eighth bit", chip_rst_o, 1);
        count_rst(len);
        chk("R4 command reset length", len, 16);
        fall_after(HI);
        repeat (20) @(negedge clk);

        // sync command
        send_bits(8'hFC, 7);
        rise(1'b0);
        edge_wait(3);
        chk("R7 filter clear pulse", filt_clr_o, 1);
        chk("R7 hold set", mod_hold_o, 1);
        chk("R7 drdy forced high", drdy_n_o, 1);
        edge_wait(1);
        chk("R7 filter clear one cycle", filt_clr_o, 0);
        fall_after(HI);
        repeat (30) @(negedge clk);
        chk("R8 hold kept without sclk", mod_hold_o, 1);
        chk("R8 drdy kept high during hold", drdy_n_o, 1);
        rise(1'b1);
        edge_wait(2);
        chk("R8 hold not released early", mod_hold_o, 1);
        edge_wait(1);
        chk("R8 hold released", mod_hold_o, 0);
        edge_wait(11);
        chk("R9 drdy still high at 11", drdy_n_o, 1);
        edge_wait(1);
        chk("R9 drdy low at 12", drdy_n_o, 0);
        fall_after(HI);
        send_bits(8'h00, 7);

        // random command bytes
        for (int k = 0; k < 20; k++) begin
            b = 8'($urandom);
            if (k == 5) b = 8'hFC;
            e = cmd_effect(b);
            send_bits(b, 7);
            rise(b[0]);
            edge_wait(4);
            chk("R10 random byte reset", chip_rst_o, e == 1);
            chk("R10 random byte hold", mod_hold_o, e == 2);
            fall_after(HI);
            if (e == 1) wait_rst_low();
            if (e == 2) send_bits(8'h00, 8);
        end
        repeat (10) @(negedge clk);

        // pattern reset
        pulse(20);
        pulse(2);
        pulse(20);
        @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        edge_wait(2);
        chk("R5 pattern not before third edge", chip_rst_o, 0);
        edge_wait(1);
        chk("R5 pattern reset", chip_rst_o, 1);
        count_rst(len);
        chk("R4 pattern reset length", len, 16);
        repeat (10) @(negedge clk);

        // deviation then full pattern
        pulse(20);
        pulse(2);
        pulse(2);
        chk("R6 deviation gives no reset", chip_rst_o, 0);
        pulse(20);
        pulse(2);
        pulse(20);
        chk("R6 partial restart no reset", chip_rst_o, 0);
        @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        edge_wait(3);
        chk("R6 pattern after restart", chip_rst_o, 1);
        wait_rst_low();
        repeat (10) @(negedge clk);

        // pin reset during sync hold
        send_bits(8'hFC, 8);
        repeat (4) @(negedge clk);
        chk("R7 hold before pin reset", mod_hold_o, 1);
        @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R11 hold cleared by pin", mod_hold_o, 0);
        chk("R11 drdy high under pin", drdy_n_o, 1);
        rst_pin_n = 1'b1;
        wait_rst_low();
        repeat (5) @(negedge clk);

        finish_run();
    end
endmodule